// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous page-mode DRAM alive. It runs the power-up start sequence, then issues periodic distributed refresh cycles in which CAS is lowered before RAS. The memory then advances its own internal row counter, so the block needs no row address. After reset it waits out the mandatory power-up pause. Once the pause is over it asks for the memory bus and runs a fixed burst of eight refresh cycles. When that burst has finished it raises `init_done`, which tells the access sequencer that normal traffic may start.

After initialisation, a free-running interval timer produces one refresh tick per slot. The slot is 15.6 us when rows are refreshed at 4K density and half that at 8K density. The block owns the RAS/CAS/W strobes only between a grant and its own release. It requests the bus and waits for the sequencer to close its open row and answer with a grant. The sequencer is expected to give a raised request priority over new host work, without cutting short a column access already in progress. Ticks that arrive while the grant is withheld are stored in a small debt counter. All stored ticks are then served back to back in one grant.

All timing is counted in clock cycles. The defaults assume a 5 ns clock and the slowest speed grade.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held, `ras_n`, `cas_n` and `we_n` are high and `ref_req` and `init_done` are low.
- R2: `ref_req` first rises exactly `INIT_WAIT_CYC` cycles after reset is released. No strobe goes low before that.
- R3: The first grant produces exactly `INIT_BURST` (8) refresh cycles back to back. `init_done` stays low until RAS returns high at the end of the last of them, and it is high from that cycle on.
- R4: At every RAS falling edge, CAS has already been low for at least `T_CSR_CYC` cycles. CAS then stays low for at least `T_CHR_CYC` cycles after RAS falls, so RAS never falls while CAS is high.
- R5: `we_n` is high in every cycle, so a refresh can never be taken for a test-mode entry.
- R6: RAS stays low for exactly `T_RAS_CYC` cycles per refresh. Before each RAS fall, RAS has been high for at least T_PRE cycles, where T_PRE = max(`T_RP_CYC`, `T_RC_CYC` - `T_RAS_CYC` - `T_CSR_CYC`). Two successive RAS falls are at least `T_RC_CYC` cycles apart.
- R7: The strobes are driven low only while `ref_gnt` is high. Once `ref_req` is raised, it is held until the precharge that follows the session's last refresh has ended.
- R8: After `init_done`, one refresh tick is produced every `REFI_4K_CYC` cycles when `dens_8k` is 0, and every `REFI_8K_CYC` cycles when it is 1. If the grant is immediate, successive refreshes start exactly that many cycles apart.
- R9: Ticks that are not served accumulate up to `DEBT_MAX` (8) and are issued back to back within one grant. Ticks beyond `DEBT_MAX` are dropped.
- R10: `ref_req` falls with both strobes high once the debt is empty. It is not raised again before a new tick arrives, and not while `ref_gnt` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dens_8k | input | 1 | 0 selects 4K-row refresh spacing, 1 selects 8K-row spacing |
| ref_req | output | 1 | Request for ownership of the DRAM strobes |
| ref_gnt | input | 1 | Grant from the access sequencer (row closed, bus handed over) |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, held high |
| init_done | output | 1 | Power-up sequence complete |

## Verification
The following properties are checked on every cycle:
- CAS leads each RAS fall.
- The RAS low width is exact.
- The strobes never move without a grant.
- The request is never withdrawn while a grant is pending, and it falls only with both strobes high.
- No request appears before the power-up pause has elapsed.
- The debt never exceeds its cap.
- `init_done` rises only together with a RAS rise.

Only the bench scenarios can show the counted behaviour:
- the eight-cycle start burst;
- the exact tick spacing in both density modes;
- that withheld ticks come back as the right number of back-to-back cycles;
- that saturation drops the surplus.

// File: rtl/cbr_refresh_sched.sv
`timescale 1ns/1ps
module cbr_refresh_sched #(
  parameter int INIT_WAIT_CYC = 40000,
  parameter int REFI_4K_CYC   = 3120,
  parameter int REFI_8K_CYC   = 1560,
  parameter int INIT_BURST    = 8,
  parameter int DEBT_MAX      = 8,
  parameter int T_RP_CYC      = 8,
  parameter int T_CSR_CYC     = 1,
  parameter int T_CHR_CYC     = 2,
  parameter int T_RAS_CYC     = 12,
  parameter int T_RC_CYC      = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dens_8k,
  output logic ref_req,
  input  logic ref_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done
);
  localparam int RC_GAP    = T_RC_CYC - T_RAS_CYC - T_CSR_CYC;
  localparam int T_PRE_CYC = (T_RP_CYC > RC_GAP) ? T_RP_CYC : RC_GAP;
  localparam int LONG1     = (INIT_WAIT_CYC > T_PRE_CYC) ? INIT_WAIT_CYC : T_PRE_CYC;
  localparam int LONGEST   = (LONG1 > T_RAS_CYC) ? LONG1 : T_RAS_CYC;
  localparam int CW        = $clog2(LONGEST + 1);
  localparam int REFI_MAX  = (REFI_4K_CYC > REFI_8K_CYC) ? REFI_4K_CYC : REFI_8K_CYC;
  localparam int TW        = $clog2(REFI_MAX + 1);
  localparam int DW        = $clog2(DEBT_MAX + 1);
  localparam int IW        = $clog2(INIT_BURST + 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_REQ, S_PRE, S_CSU, S_RLO} st_t;

  st_t           st;
  logic [CW-1:0] tcnt;
  logic [TW-1:0] tmr;
  logic [DW-1:0] debt;
  logic [IW-1:0] init_cnt;

  wire [TW-1:0] refi_m1  = dens_8k ? TW'(REFI_8K_CYC - 1) : TW'(REFI_4K_CYC - 1);
  wire          tick     = init_done && (tmr == refi_m1);
  wire          cyc_done = (st == S_RLO) && (tcnt == CW'(T_RAS_CYC - 1));
  wire          pay_debt = cyc_done && (init_cnt == '0);
  wire          pending  = (init_cnt != '0) || (debt != '0);

  assign ref_req = (st == S_REQ) || (st == S_PRE) || (st == S_CSU) || (st == S_RLO);
  assign ras_n   = (st != S_RLO);
  assign cas_n   = !((st == S_CSU) || ((st == S_RLO) && (tcnt < CW'(T_CHR_CYC))));
  assign we_n    = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (init_done) begin
      tmr <= (tmr >= refi_m1) ? '0 : tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      debt <= '0;
    end else begin
      case ({tick, pay_debt})
        2'b10:   if (debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
        2'b01:   debt <= debt - 1'b1;
        default: debt <= debt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt  <= IW'(INIT_BURST);
      init_done <= 1'b0;
    end else if (cyc_done && init_cnt != '0) begin
      init_cnt <= init_cnt - 1'b1;
      if (init_cnt == IW'(1)) init_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      tcnt <= '0;
    end else begin
      case (st)
        S_WAIT: begin
          if (tcnt == CW'(INIT_WAIT_CYC - 1)) begin
            st   <= S_REQ;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_IDLE: if (debt != '0 && !ref_gnt) st <= S_REQ;
        S_REQ: begin
          if (ref_gnt) begin
            st   <= S_PRE;
            tcnt <= '0;
          end
        end
        S_PRE: begin
          if (tcnt == CW'(T_PRE_CYC - 1)) begin
            st   <= pending ? S_CSU : S_IDLE;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_CSU: begin
          if (tcnt == CW'(T_CSR_CYC - 1)) begin
            st   <= S_RLO;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_RLO: begin
          if (cyc_done) begin
            st   <= S_PRE;
            tcnt <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          st   <= S_IDLE;
          tcnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
`timescale 1ns/1ps
module cbr_refresh_sched_chk #(
  parameter int INIT_WAIT_CYC = 40000,
  parameter int T_RAS_CYC     = 12,
  parameter int DEBT_MAX      = 8,
  parameter int DW            = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_req,
  input logic          ref_gnt,
  input logic          ras_n,
  input logic          cas_n,
  input logic          init_done,
  input logic [DW-1:0] debt
);
  localparam int WW = $clog2(INIT_WAIT_CYC + 1);
  localparam int LW = $clog2(T_RAS_CYC + 2);

  logic [WW-1:0] wait_cnt;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= '0;
      low_cnt  <= '0;
    end else begin
      if (wait_cnt != WW'(INIT_WAIT_CYC)) wait_cnt <= wait_cnt + 1'b1;
      if (ras_n) low_cnt <= '0;
      else if (low_cnt != LW'(T_RAS_CYC + 1)) low_cnt <= low_cnt + 1'b1;
    end
  end

  // R2
  early_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> wait_cnt == WW'(INIT_WAIT_CYC));

  // R3
  init_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $rose(ras_n));

  // R4
  cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  // R6
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> low_cnt == LW'(T_RAS_CYC));

  // R7
  strobe_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> ref_gnt);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  // R9
  debt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debt <= DW'(DEBT_MAX));

  // R10
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_req) |-> (ras_n && cas_n && $past(ras_n)));
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk #(
  .INIT_WAIT_CYC(INIT_WAIT_CYC),
  .T_RAS_CYC(T_RAS_CYC),
  .DEBT_MAX(DEBT_MAX),
  .DW(DW)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .ref_req(ref_req),
  .ref_gnt(ref_gnt),
  .ras_n(ras_n),
  .cas_n(cas_n),
  .init_done(init_done),
  .debt(debt)
);

// File: tb/cbr_refresh_sched_test.sv
`timescale 1ns/1ps
module cbr_refresh_sched_test;
  localparam int INIT_WAIT = 400;
  localparam int REFI4     = 256;
  localparam int REFI8     = 128;
  localparam int BURST     = 8;
  localparam int DMAX      = 8;
  localparam int TRP = 8, TCSR = 1, TCHR = 2, TRAS = 12, TRC = 22;
  localparam int TPRE = (TRP > TRC - TRAS - TCSR) ? TRP : TRC - TRAS - TCSR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dens_8k = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ras_n, cas_n, we_n, init_done;
  bit   gnt_en = 1'b1;

  int tests = 0, fails = 0;
  int cbr_total = 0;
  int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0;

  always #2.5 clk = ~clk;

  cbr_refresh_sched #(
    .INIT_WAIT_CYC(INIT_WAIT), .REFI_4K_CYC(REFI4), .REFI_8K_CYC(REFI8),
    .INIT_BURST(BURST), .DEBT_MAX(DMAX), .T_RP_CYC(TRP), .T_CSR_CYC(TCSR),
    .T_CHR_CYC(TCHR), .T_RAS_CYC(TRAS), .T_RC_CYC(TRC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .dens_8k(dens_8k), .ref_req(ref_req),
    .ref_gnt(ref_gnt), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .init_done(init_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // timing monitor and sequencer model, both at the falling edge
  initial begin
    logic p_ras = 1'b1, p_cas = 1'b1;
    int ras_lo = 0, ras_hi = 1000, cas_lo = 0;
    longint last_fall = -1000;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (p_ras && !ras_n) begin
          cbr_total++;
          if (cas_n || cas_lo < TCSR) v_r4++;
          if (ras_hi < TPRE) v_r6++;
          if (($time - last_fall) / 5 < TRC) v_r6++;
          if (cbr_total <= BURST && init_done) v_r3++;
          last_fall = $time;
        end
        if (!p_ras && ras_n) begin
          if (ras_lo != TRAS) v_r6++;
          if (cbr_total == BURST && !init_done) v_r3++;
        end
        if (!p_cas && cas_n && !p_ras && ras_lo < TCHR) v_r4++;
        if ((!ras_n || !cas_n) && !ref_gnt) v_r7++;
        if (we_n !== 1'b1) v_r5++;
        ras_lo = ras_n ? 0 : ras_lo + 1;
        ras_hi = ras_n ? ras_hi + 1 : 0;
        cas_lo = cas_n ? 0 : cas_lo + 1;
        p_ras = ras_n;
        p_cas = cas_n;
      end
      ref_gnt = gnt_en && ref_req;
    end
  end

  task automatic wait_req_rise();
    do @(negedge clk); while (!ref_req);
  endtask

  task automatic run_session(output int n, output longint t_fall);
    int c0;
    wait_req_rise();
    c0 = cbr_total;
    do @(negedge clk); while (ras_n);
    t_fall = $time;
    do @(negedge clk); while (ref_req);
    n = cbr_total - c0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R1
    chk(ras_n && cas_n && we_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ref_req && !init_done, "R1 req/init_done low in reset", {ref_req, init_done}, 0);
  endtask

  task automatic t_init();
    int k = 0, n;
    longint tf;
    rst_n = 1'b1;
    do begin @(negedge clk); k++; end while (!ref_req && k < 5 * INIT_WAIT);
    // R2
    chk(k == INIT_WAIT, "R2 first request after power-up pause", k, INIT_WAIT);
    chk(cbr_total == 0, "R2 no strobe before pause", cbr_total, 0);
    chk(!init_done, "R3 init_done low before burst", init_done, 0);
    c_session(n, tf);
    chk(n == BURST, "R3 initial burst length", n, BURST);
    chk(init_done, "R3 init_done high after burst", init_done, 1);
  endtask

  task automatic c_session(output int n, output longint tf);
    int c0;
    c0 = cbr_total;
    do @(negedge clk); while (ras_n);
    tf = $time;
    do @(negedge clk); while (ref_req);
    n = cbr_total - c0;
  endtask

  task automatic t_interval(input bit d8, input int refi, input string tag);
    int n;
    longint t0, t1, t2;
    dens_8k = d8;
    run_session(n, t0);
    run_session(n, t1);
    // R9
    chk(n == 1, "R9 one cycle per served tick", n, 1);
    repeat (5) @(negedge clk);
    // R10
    chk(!ref_req && ras_n && cas_n, "R10 released and quiet after session", ref_req, 0);
    run_session(n, t2);
    // R8
    chk((t1 - t0) / 5 == refi, tag, int'((t1 - t0) / 5), refi);
    chk((t2 - t1) / 5 == refi, tag, int'((t2 - t1) / 5), refi);
  endtask

  task automatic t_debt(input int extra, input int expect_n, input string tag);
    int n;
    longint tf;
    gnt_en = 1'b0;
    wait_req_rise();
    repeat (extra * REFI4 + 5) @(negedge clk);
    // R7
    chk(ref_req && ras_n && cas_n, "R7 request held while grant withheld", ref_req, 1);
    gnt_en = 1'b1;
    c_session(n, tf);
    chk(n == expect_n, tag, n, expect_n);
  endtask

  initial begin
    int n;
    longint tf;
    t_reset();
    t_init();
    t_interval(1'b0, REFI4, "R8 4K tick spacing");
    t_interval(1'b1, REFI8, "R8 8K tick spacing");
    dens_8k = 1'b0;
    run_session(n, tf);
    t_debt(2, 3, "R9 three stored ticks served back to back");
    t_debt(10, DMAX, "R9 debt saturates at cap");
    run_session(n, tf);
    chk(n == 1, "R9 surplus ticks dropped", n, 1);
    chk(v_r3 == 0, "R3 init_done timing events", v_r3, 0);
    chk(v_r4 == 0, "R4 CAS setup/hold violations", v_r4, 0);
    chk(v_r5 == 0, "R5 W low events", v_r5, 0);
    chk(v_r6 == 0, "R6 RAS width/precharge violations", v_r6, 0);
    chk(v_r7 == 0, "R7 strobes without grant", v_r7, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule